// File: doc/BRIEF.md
# Cascaded Pulse Accumulator Pair

This block counts events arriving on two external pins. Each pin feeds an 8-bit counter through a two-flop synchroniser and an edge detector. The counter picks its counting edge, rising or falling, from a control bit. The two counters can run apart, each on its own pin. When the chain bit is set they form one 16-bit counter instead. In that case the upper byte advances only on a carry out of the lower byte, and the upper pin is ignored.

Software reaches the counts, the control byte and a sticky overflow flag through a small register port. The port takes byte accesses and, at the count address, a 16-bit word access. A word read or write moves both count bytes in one cycle, so the value is coherent. Two byte accesses in a row may see a count that changed between them. The overflow flag is set whenever the upper byte wraps. Writing a one clears it. The flag, gated by an enable bit, drives the interrupt request.

Top module: `pa_cascade_pair`

## Requirements
- R1: After a synchronous reset, both counts, the control byte, the overflow flag and `irq_o` are 0.
- R2: With the chain bit clear, each counter increments by one for each selected edge on its own pin. The new value is visible on the third rising clock edge after the pin changes (two synchroniser flops, then the counter register).
- R3: Control bit 3 picks the lower counter's edge and control bit 4 the upper counter's edge: 0 counts rising edges, 1 counts falling edges. The other edge does not count.
- R4: While control bit 2 (run) is 0, no edge changes either count.
- R5: With control bit 0 (chain) set, the lower count advances on its pin. Its wrap from 0xFF to 0x00 increments the upper count in the same clock cycle. Edges on the upper pin have no effect.
- R6: The overflow flag (bit 0 at address 3) is set when the upper count wraps from 0xFF to 0x00, in either mode. A wrap of the lower count that does not carry the upper count out of 0xFF leaves it clear.
- R7: Writing a 1 to bit 0 at address 3 clears the flag, and writing a 0 leaves it unchanged. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R8: `irq_o` is 1 exactly when the flag is 1 and control bit 1 (interrupt enable) is 1.
- R9: At address 0 with `bus_word_i` high, a read returns the upper count in bits 15:8 and the lower count in bits 7:0. A write loads both counts from those bits in one cycle.
- R10: Byte accesses use address 0 for the upper count, 1 for the lower count and 2 for the control byte. Data sits in bits 7:0 and read bits 15:8 are zero. A byte write loads only the addressed register, from `bus_wdata_i[7:0]`.
- R11: A write to a count register in the same cycle as an increment of that register wins. The increment is lost, and it produces no carry and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_lo_i | input | 1 | Event pin of the lower counter (asynchronous) |
| evt_hi_i | input | 1 | Event pin of the upper counter (asynchronous) |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_word_i | input | 1 | Word access at address 0 |
| bus_sel_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change made at a falling clock edge reaches its count on the third rising edge after it. The bench therefore waits three falling edges after each pin change before it reads a count. Register writes take effect on the next rising edge, and the read port is combinational, so each check is sampled at least one falling edge after the write. Same-cycle collisions (R7, R11) are staged by raising the write strobe on the falling edge just before the third rising edge, so the write and the increment land on the same edge.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [1:0] {
        SEL_CNT_HI = 2'd0,
        SEL_CNT_LO = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_FLAG   = 2'd3
    } reg_sel_e;

    // bit 0 chain, 1 irq enable, 2 run, 3 lower falling, 4 upper falling
    typedef struct packed {
        logic fall_hi;
        logic fall_lo;
        logic run;
        logic irq_en;
        logic chain;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    function automatic logic edge_hit(input logic cur, input logic prev, input logic falling);
        return falling ? (prev & ~cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic falling_i,
    output logic hit_o
);
    import pa_pkg::*;

    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], pin_i};
    end

    assign hit_o = edge_hit(chain_q[STAGES-1], chain_q[STAGES], falling_i);

endmodule

// File: rtl/pa_byte_counter.sv
module pa_byte_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = '1;

    assign wrap_o = inc_i & ~ld_i & (cnt_o == TOP);

    always_ff @(posedge clk) begin
        if (rst)        cnt_o <= '0;
        else if (ld_i)  cnt_o <= ld_val_i;
        else if (inc_i) cnt_o <= cnt_o + 1'b1;
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !ld_i) |=> cnt_o == $past(cnt_o) + 1'b1);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !ld_i) |=> $stable(cnt_o));

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ld_i |=> cnt_o == $past(ld_val_i));

endmodule

// File: rtl/pa_cascade_pair.sv
module pa_cascade_pair #(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_lo_i,
    input  logic               evt_hi_i,
    input  logic               bus_wr_i,
    input  logic               bus_word_i,
    input  logic [1:0]         bus_sel_i,
    input  logic [2*CNT_W-1:0] bus_wdata_i,
    output logic [2*CNT_W-1:0] bus_rdata_o,
    output logic               irq_o
);
    import pa_pkg::*;

    localparam int unsigned NCH  = 2;   // index 0 lower, 1 upper
    localparam int unsigned DW   = 2 * CNT_W;

    reg_sel_e         sel;
    ctrl_t            ctrl_q;
    logic             flag_q;
    logic [NCH-1:0]   pin;
    logic [NCH-1:0]   fall;
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   inc;
    logic [NCH-1:0]   ld;
    logic [NCH-1:0]   wrap;
    logic [CNT_W-1:0] ld_val [NCH];
    logic [CNT_W-1:0] cnt    [NCH];
    logic             wr_ctrl;
    logic             wr_clr;

    assign sel     = reg_sel_e'(bus_sel_i);
    assign pin     = {evt_hi_i, evt_lo_i};
    assign fall    = {ctrl_q.fall_hi, ctrl_q.fall_lo};
    assign wr_ctrl = bus_wr_i && (sel == SEL_CTRL);
    assign wr_clr  = bus_wr_i && (sel == SEL_FLAG) && bus_wdata_i[0];

    // register port decode for the count loads
    assign ld[1]     = bus_wr_i && (sel == SEL_CNT_HI);
    assign ld_val[1] = bus_word_i ? bus_wdata_i[DW-1:CNT_W] : bus_wdata_i[CNT_W-1:0];
    assign ld[0]     = bus_wr_i && ((sel == SEL_CNT_LO) || (sel == SEL_CNT_HI && bus_word_i));
    assign ld_val[0] = bus_wdata_i[CNT_W-1:0];

    // increment sources: upper byte takes the carry when chained
    assign inc[0] = ctrl_q.run & hit[0];
    assign inc[1] = ctrl_q.run & (ctrl_q.chain ? wrap[0] : hit[1]);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pa_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst       (rst),
            .pin_i     (pin[g]),
            .falling_i (fall[g]),
            .hit_o     (hit[g])
        );

        pa_byte_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .inc_i    (inc[g]),
            .ld_i     (ld[g]),
            .ld_val_i (ld_val[g]),
            .cnt_o    (cnt[g]),
            .wrap_o   (wrap[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
    end

    // set has priority over the write-one clear
    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (wrap[1]) flag_q <= 1'b1;
        else if (wr_clr)  flag_q <= 1'b0;
    end

    assign irq_o = flag_q & ctrl_q.irq_en;

    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            SEL_CNT_HI: begin
                if (bus_word_i) bus_rdata_o = {cnt[1], cnt[0]};
                else            bus_rdata_o[CNT_W-1:0] = cnt[1];
            end
            SEL_CNT_LO: bus_rdata_o[CNT_W-1:0] = cnt[0];
            SEL_CTRL:   bus_rdata_o[CTRL_W-1:0] = ctrl_q;
            SEL_FLAG:   bus_rdata_o[0] = flag_q;
            default:    bus_rdata_o = '0;
        endcase
    end

    // R5
    carry_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.chain && ctrl_q.run && wrap[0] && !ld[1]) |=> cnt[1] == $past(cnt[1]) + 1'b1);

    // R6
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(wrap[1]));

    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !wrap[1]) |=> !flag_q);

    // R9
    word_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (ld[1] && bus_word_i) |=> {cnt[1], cnt[0]} == $past(bus_wdata_i));

    // R8
    irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (flag_q && ctrl_q.irq_en));

endmodule

// File: tb/pa_cascade_pair_bench.sv
`timescale 1ns/1ps
module pa_cascade_pair_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_lo = 1'b0;
    logic        evt_hi = 1'b0;
    logic        wr = 1'b0;
    logic        word = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    pa_cascade_pair u_pa_cascade_pair (
        .clk         (clk),
        .rst         (rst),
        .evt_lo_i    (evt_lo),
        .evt_hi_i    (evt_hi),
        .bus_wr_i    (wr),
        .bus_word_i  (word),
        .bus_sel_i   (sel),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [15:0] exp;
    } item_t;

    item_t sb[$];
    event  chk_ev;
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    // monitor: pops expectations and compares with the port values
    always @(chk_ev) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {15'b0, irq} : rdata;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push_chk(input bit is_irq, input logic [15:0] exp, input string tag);
        item_t it;
        it.tag = tag; it.is_irq = is_irq; it.exp = exp;
        #1;
        sb.push_back(it);
        -> chk_ev;
        #0.5;
    endtask

    task automatic check(input logic [1:0] s, input bit w, input logic [15:0] exp, input string tag);
        sel = s; word = w;
        push_chk(1'b0, exp, tag);
    endtask

    task automatic check_irq(input logic e, input string tag);
        push_chk(1'b1, {15'b0, e}, tag);
    endtask

    task automatic bus_write(input logic [1:0] s, input bit w, input logic [15:0] d);
        @(negedge clk);
        sel = s; word = w; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic set_pin(input bit which, input logic lvl);
        @(negedge clk);
        if (which) evt_hi = lvl; else evt_lo = lvl;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input bit which);
        set_pin(which, 1'b1);
        set_pin(which, 1'b0);
    endtask

    // rising pin edge whose count update coincides with a register write
    task automatic pulse_with_write(input bit which, input logic [1:0] s, input bit w, input logic [15:0] d);
        @(negedge clk);
        if (which) evt_hi = 1'b1; else evt_lo = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sel = s; word = w; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        repeat (2) @(negedge clk);
        set_pin(which, 1'b0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check(2'd0, 1'b1, 16'h0000, "R1 count word after reset");
        check(2'd2, 1'b0, 16'h0000, "R1 control after reset");
        check(2'd3, 1'b0, 16'h0000, "R1 flag after reset");
        check_irq(1'b0, "R1 irq after reset");

        pulse(1'b0);
        check(2'd1, 1'b0, 16'h0000, "R4 lower count held while stopped");

        bus_write(2'd2, 1'b0, 16'h0004);
        pulse(1'b0);
        check(2'd1, 1'b0, 16'h0001, "R2 lower counts own pin");
        pulse(1'b1);
        check(2'd0, 1'b0, 16'h0001, "R2 upper counts own pin");
        check(2'd1, 1'b0, 16'h0001, "R2 lower untouched by upper pin");

        bus_write(2'd2, 1'b0, 16'h000C);
        set_pin(1'b0, 1'b1);
        check(2'd1, 1'b0, 16'h0001, "R3 rising edge ignored in falling mode");
        set_pin(1'b0, 1'b0);
        check(2'd1, 1'b0, 16'h0002, "R3 falling edge counts");

        bus_write(2'd2, 1'b0, 16'h0004);
        bus_write(2'd1, 1'b0, 16'h007F);
        check(2'd1, 1'b0, 16'h007F, "R10 lower byte write");
        check(2'd0, 1'b0, 16'h0001, "R10 upper unchanged by lower write");
        bus_write(2'd0, 1'b0, 16'hAB42);
        check(2'd0, 1'b0, 16'h0042, "R10 upper byte write from low data bits");
        check(2'd1, 1'b0, 16'h007F, "R10 lower unchanged by upper write");

        bus_write(2'd0, 1'b1, 16'h12FF);
        check(2'd0, 1'b1, 16'h12FF, "R9 word write and read");
        bus_write(2'd2, 1'b0, 16'h0005);
        pulse(1'b0);
        check(2'd0, 1'b1, 16'h1300, "R5 carry into upper byte");
        pulse(1'b1);
        check(2'd0, 1'b1, 16'h1300, "R5 upper pin ignored when chained");
        check(2'd3, 1'b0, 16'h0000, "R6 lower wrap alone leaves flag clear");

        bus_write(2'd0, 1'b1, 16'hFFFF);
        pulse(1'b0);
        check(2'd0, 1'b1, 16'h0000, "R6 chained count wraps");
        check(2'd3, 1'b0, 16'h0001, "R6 flag set on upper wrap");
        check_irq(1'b0, "R8 irq masked");
        bus_write(2'd2, 1'b0, 16'h0007);
        check_irq(1'b1, "R8 irq enabled");

        bus_write(2'd3, 1'b0, 16'h0000);
        check(2'd3, 1'b0, 16'h0001, "R7 writing zero keeps flag");
        bus_write(2'd3, 1'b0, 16'h0001);
        check(2'd3, 1'b0, 16'h0000, "R7 write one clears flag");
        check_irq(1'b0, "R8 irq drops with flag");

        bus_write(2'd2, 1'b0, 16'h0005);
        bus_write(2'd0, 1'b1, 16'h05FF);
        pulse_with_write(1'b0, 2'd1, 1'b0, 16'h0020);
        check(2'd0, 1'b1, 16'h0520, "R11 write beats increment, no carry");
        check(2'd3, 1'b0, 16'h0000, "R11 no flag from lost increment");

        bus_write(2'd0, 1'b1, 16'hFFFF);
        pulse_with_write(1'b0, 2'd3, 1'b0, 16'h0001);
        check(2'd0, 1'b1, 16'h0000, "R7 wrap during clear write");
        check(2'd3, 1'b0, 16'h0001, "R7 set wins over clear");

        bus_write(2'd3, 1'b0, 16'h0001);
        bus_write(2'd2, 1'b0, 16'h0006);
        bus_write(2'd0, 1'b0, 16'h00FF);
        pulse(1'b1);
        check(2'd0, 1'b0, 16'h0000, "R6 upper wraps in independent mode");
        check(2'd1, 1'b0, 16'h0000, "R6 lower unchanged by upper wrap");
        check(2'd3, 1'b0, 16'h0001, "R6 flag set in independent mode");
        check_irq(1'b1, "R8 irq in independent mode");

        done = 1'b1;
        finish_run();
    end

endmodule